// File: doc/BRIEF.md
# Vectored Interrupt Priority Address Substitution

This block sits on the 16-bit address path between a small CPU and its memory. It takes eleven active-low interrupt requests and merges them into a single active-low interrupt line to the CPU. The CPU always fetches its interrupt start address from the same byte pair. The block detects that fetch and overrides address bits 4 to 1, so the read lands on a vector pair that belongs to the most urgent active requester. It does not supply any vector data itself: the vector memory still answers the fetch.

Thirteen byte pairs, from 0xFFE0 to 0xFFF9, can be selected. Pairs 0 to 10 belong to the individual requesters. Pairs 11 and 12 are kept for two chosen combinations of simultaneous requests. Three status flags report chosen request combinations, for example to drive a non-maskable interrupt, a halt line or an indicator. A chip-enable input releases the address outputs, so that another bus master, such as a DMA engine, can drive the bus. The whole path is combinational.

Top module: `irq_vec_subst`

## Requirements
- R1: `irqN` is low exactly when at least one bit of `reqN` is low. A low bit on `reqN` means that requester is active.
- R2: A vector fetch is recognised only when all three of these hold: `vma` is 1, `addrIn[15:5]` is all ones, and `addrIn[4:1]` equals 4'b1100. `addrIn[0]` may be either value, so both 0xFFF8 and 0xFFF9 are recognised. Any other address, or `vma` at 0, leaves `addrOut` equal to `addrIn`.
- R3: During a recognised fetch with no combination matched, `addrOut[4:1]` takes the index of the lowest-numbered active requester (index 0 has the highest priority). Bits 15 to 5 and bit 0 pass through unchanged.
- R4: During a recognised fetch, if every requester in `COMBO0_MASK` is active (default: requesters 0 and 1), `addrOut[4:1]` becomes 4'd11 (0xFFF6/0xFFF7). This takes precedence over R5 and R3.
- R5: During a recognised fetch, if R4 does not apply and every requester in `COMBO1_MASK` is active (default: requesters 3 and 4), `addrOut[4:1]` becomes 4'd12. This takes precedence over R3.
- R6: When no requester is active, `addrOut` equals `addrIn`, even during a recognised fetch.
- R7: When `chipEnN` is 1, `addrDrive` is 0 and `addrOut` is released to high impedance. When `chipEnN` is 0, `addrDrive` is 1. `chipEnN` has no effect on `irqN` or `flags`.
- R8: Bit k of `flags` is 1 exactly when every requester in mask k of `FLAG_MASKS` is active. The default masks are:
  - bit 0: requesters 0 and 2
  - bit 1: requesters 9 and 10
  - bit 2: requester 5

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vma | input | 1 | CPU valid-memory-address qualifier, active high |
| addrIn | input | 16 | Address driven by the CPU |
| reqN | input | 11 | Interrupt requests, active low, bit 0 has the highest priority |
| chipEnN | input | 1 | Active-low output enable for the address outputs |
| addrOut | output | 16 | Address sent to memory, high impedance when disabled |
| addrDrive | output | 1 | High while `addrOut` is driven |
| irqN | output | 1 | Merged interrupt request to the CPU, active low |
| flags | output | 3 | Combination status flags, active high |

## Verification
The assertions assume that the inputs are settled, known values whenever the combinational outputs are examined. They also assume that the CPU's address reflects a single bus cycle at a time. The bench changes every input together just after a rising edge and compares against its behavioural model on the falling edge, so no check ever sees a half-updated input set. The request patterns deliberately include masks that overlap, such as a combination together with a lower-priority requester, or both combinations at once. These patterns exercise the precedence ordering and not only isolated requests.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int SEL_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic             override;
    logic [SEL_W-1:0] pairSel;
  } vecStrobe_t;
endpackage

// File: rtl/irq_vec_prio.sv
module irq_vec_prio #(
  parameter int NUM_REQ = 11,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] active,
  output logic               anyHit,
  output logic [IDX_W-1:0]   topIdx
);
  // seen[k] is high when some requester below k is active
  logic [NUM_REQ:0] seen;
  logic [NUM_REQ-1:0] winner;

  assign seen[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < NUM_REQ; k++) begin : g_chain
      assign winner[k]  = active[k] & ~seen[k];
      assign seen[k+1]  = seen[k] | active[k];
    end
  endgenerate

  assign anyHit = seen[NUM_REQ];

  always_comb begin
    topIdx = '0;
    for (int j = 0; j < NUM_REQ; j++) begin
      if (winner[j]) topIdx = IDX_W'(j);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_REQ    = 11,
  parameter int NUM_FLAGS  = 3,
  parameter int ADDR_W     = 16,
  parameter int SEL_LSB    = 1,
  parameter int FETCH_PAIR = 12,
  parameter int COMBO0_PAIR = 11,
  parameter int COMBO1_PAIR = 12,
  parameter logic [NUM_REQ-1:0] COMBO0_MASK = 11'h003,
  parameter logic [NUM_REQ-1:0] COMBO1_MASK = 11'h018,
  parameter logic [NUM_FLAGS*NUM_REQ-1:0] FLAG_MASKS = {11'h020, 11'h600, 11'h005}
) (
  input  logic                 vma,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [NUM_REQ-1:0]   reqN,
  output vecStrobe_t           strobe,
  output logic                 irqN,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int IDX_W = $clog2(NUM_REQ);
  localparam int UP_W  = ADDR_W - SEL_LSB - SEL_W;

  logic [NUM_REQ-1:0] active;
  logic               anyHit;
  logic [IDX_W-1:0]   topIdx;
  logic               fetchHit;
  logic               combo0Hit;
  logic               combo1Hit;

  assign active = ~reqN;

  irq_vec_prio #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_prio (
    .active (active),
    .anyHit (anyHit),
    .topIdx (topIdx)
  );

  assign fetchHit = vma
                  && (&addrIn[ADDR_W-1 -: UP_W])
                  && (addrIn[SEL_LSB +: SEL_W] == SEL_W'(FETCH_PAIR));

  assign combo0Hit = (COMBO0_MASK != '0) && ((active & COMBO0_MASK) == COMBO0_MASK);
  assign combo1Hit = (COMBO1_MASK != '0) && ((active & COMBO1_MASK) == COMBO1_MASK);

  genvar f;
  generate
    for (f = 0; f < NUM_FLAGS; f++) begin : g_flag
      localparam logic [NUM_REQ-1:0] FMASK = FLAG_MASKS[f*NUM_REQ +: NUM_REQ];
      assign flags[f] = (FMASK != '0) && ((active & FMASK) == FMASK);
    end
  endgenerate

  assign irqN = ~anyHit;

  always_comb begin
    strobe.override = fetchHit && anyHit;
    if (combo0Hit)      strobe.pairSel = SEL_W'(COMBO0_PAIR);
    else if (combo1Hit) strobe.pairSel = SEL_W'(COMBO1_PAIR);
    else                strobe.pairSel = SEL_W'(topIdx);
  end
endmodule

// File: rtl/irq_vec_dpath.sv
module irq_vec_dpath
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEL_LSB = 1
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  vecStrobe_t        strobe,
  input  logic              chipEnN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrDrive
);
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    addrNext = addrIn;
    if (strobe.override) addrNext[SEL_LSB +: SEL_W] = strobe.pairSel;
  end

  assign addrDrive = ~chipEnN;
  assign addrOut   = addrDrive ? addrNext : {ADDR_W{1'bz}};
endmodule

// File: rtl/irq_vec_subst.sv
module irq_vec_subst
  import irq_vec_pkg::*;
#(
  parameter int NUM_REQ     = 11,
  parameter int NUM_FLAGS   = 3,
  parameter int ADDR_W      = 16,
  parameter int SEL_LSB     = 1,
  parameter int FETCH_PAIR  = 12,
  parameter int COMBO0_PAIR = 11,
  parameter int COMBO1_PAIR = 12,
  parameter logic [NUM_REQ-1:0] COMBO0_MASK = 11'h003,
  parameter logic [NUM_REQ-1:0] COMBO1_MASK = 11'h018,
  parameter logic [NUM_FLAGS*NUM_REQ-1:0] FLAG_MASKS = {11'h020, 11'h600, 11'h005}
) (
  input  logic                 vma,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [NUM_REQ-1:0]   reqN,
  input  logic                 chipEnN,
  output logic [ADDR_W-1:0]    addrOut,
  output logic                 addrDrive,
  output logic                 irqN,
  output logic [NUM_FLAGS-1:0] flags
);
  vecStrobe_t strobe;

  irq_vec_ctrl #(
    .NUM_REQ(NUM_REQ), .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB),
    .FETCH_PAIR(FETCH_PAIR), .COMBO0_PAIR(COMBO0_PAIR), .COMBO1_PAIR(COMBO1_PAIR),
    .COMBO0_MASK(COMBO0_MASK), .COMBO1_MASK(COMBO1_MASK), .FLAG_MASKS(FLAG_MASKS)
  ) u_ctrl (
    .vma    (vma),
    .addrIn (addrIn),
    .reqN   (reqN),
    .strobe (strobe),
    .irqN   (irqN),
    .flags  (flags)
  );

  irq_vec_dpath #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)) u_dpath (
    .addrIn    (addrIn),
    .strobe    (strobe),
    .chipEnN   (chipEnN),
    .addrOut   (addrOut),
    .addrDrive (addrDrive)
  );
endmodule

// File: rtl/irq_vec_subst_chk.sv
module irq_vec_subst_chk #(
  parameter int NUM_REQ    = 11,
  parameter int ADDR_W     = 16,
  parameter int SEL_LSB    = 1,
  parameter int SEL_W      = 4,
  parameter int FETCH_PAIR = 12,
  parameter int LAST_PAIR  = 12
) (
  input logic               vma,
  input logic [ADDR_W-1:0]  addrIn,
  input logic [NUM_REQ-1:0] reqN,
  input logic               chipEnN,
  input logic [ADDR_W-1:0]  addrOut,
  input logic               addrDrive,
  input logic               irqN
);
  localparam int UP_W = ADDR_W - SEL_LSB - SEL_W;

  logic isFetch;
  assign isFetch = vma && (&addrIn[ADDR_W-1 -: UP_W])
                && (addrIn[SEL_LSB +: SEL_W] == SEL_W'(FETCH_PAIR));

  always_comb begin
    AST_IRQ_MERGE: assert (irqN == (&reqN)); // R1
    AST_DRIVE_ENABLE: assert (addrDrive == !chipEnN); // R7
    if (addrDrive) begin
      AST_NOFETCH_PASS: assert (isFetch || addrOut == addrIn); // R2
      AST_UPPER_KEPT: assert (addrOut[ADDR_W-1 -: UP_W] == addrIn[ADDR_W-1 -: UP_W]
                              && addrOut[SEL_LSB-1:0] == addrIn[SEL_LSB-1:0]); // R3
      AST_PAIR_RANGE: assert (!isFetch || addrOut[SEL_LSB +: SEL_W] <= SEL_W'(LAST_PAIR)); // R3
      AST_IDLE_PASS: assert (!(&reqN) || addrOut == addrIn); // R6
    end
  end
endmodule

bind irq_vec_subst irq_vec_subst_chk #(
  .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .FETCH_PAIR(FETCH_PAIR)
) u_chk (
  .vma       (vma),
  .addrIn    (addrIn),
  .reqN      (reqN),
  .chipEnN   (chipEnN),
  .addrOut   (addrOut),
  .addrDrive (addrDrive),
  .irqN      (irqN)
);

// File: tb/test_irq_vec_subst.sv
module test_irq_vec_subst;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vma = 1'b0;
  logic [15:0] addrIn = 16'h0000;
  logic [10:0] reqN = '1;
  logic        chipEnN = 1'b0;
  wire  [15:0] addrOut;
  logic        addrDrive;
  logic        irqN;
  logic [2:0]  flags;

  int    testCnt = 0;
  int    failCnt = 0;
  string curReq  = "R6";
  bit    done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_subst i_irq_vec_subst (
    .vma(vma), .addrIn(addrIn), .reqN(reqN), .chipEnN(chipEnN),
    .addrOut(addrOut), .addrDrive(addrDrive), .irqN(irqN), .flags(flags)
  );

  // behavioural reference, built from the requirement text
  function automatic int activeList(input logic [10:0] rn, ref int q[$]);
    q.delete();
    for (int i = 0; i < 11; i++) if (rn[i] == 1'b0) q.push_back(i);
    return q.size();
  endfunction

  function automatic bit allIn(input logic [10:0] rn, input int members[$]);
    foreach (members[m]) if (rn[members[m]] != 1'b0) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] modelAddr(input logic v, input logic [15:0] a,
                                            input logic [10:0] rn);
    int q[$];
    int pair;
    logic [15:0] r;
    r = a;
    if (v && a[15:5] == 11'h7FF && a[4:1] == 4'd12 && activeList(rn, q) > 0) begin
      if (allIn(rn, '{0, 1}))      pair = 11;  // R4
      else if (allIn(rn, '{3, 4})) pair = 12;  // R5
      else                         pair = q[0]; // R3
      r[4:1] = pair[3:0];
    end
    return r;
  endfunction

  function automatic logic [2:0] modelFlags(input logic [10:0] rn);
    logic [2:0] f;
    f[0] = allIn(rn, '{0, 2});
    f[1] = allIn(rn, '{9, 10});
    f[2] = allIn(rn, '{5});
    return f;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h (vma=%b addr=%h reqN=%b ce=%b)",
               tag, act, exp, vma, addrIn, reqN, chipEnN);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R1 irqN", 32'(irqN), 32'(&reqN));
      check("R8 flags", 32'(flags), 32'(modelFlags(reqN)));
      check("R7 addrDrive", 32'(addrDrive), 32'(!chipEnN));
      if (!chipEnN)
        check({curReq, " addrOut"}, 32'(addrOut), 32'(modelAddr(vma, addrIn, reqN)));
    end
  end

  task automatic apply(input logic v, input logic [15:0] a, input logic [10:0] rn,
                       input logic ce);
    @(posedge clk);
    vma <= v; addrIn <= a; reqN <= rn; chipEnN <= ce;
    @(posedge clk);
  endtask

  function automatic logic [10:0] reqs(input int members[$]);
    logic [10:0] rn = '1;
    foreach (members[m]) rn[members[m]] = 1'b0;
    return rn;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: idle bus, no requests
    check("R1 reset irqN", 32'(irqN), 32'h1);
    check("R8 reset flags", 32'(flags), 32'h0);

    curReq = "R6";
    apply(1, 16'hFFF8, '1, 0);
    apply(1, 16'hFFF9, '1, 0);
    apply(1, 16'h1234, '1, 0);

    curReq = "R2";
    apply(1, 16'hFFF8, reqs('{5}), 0);
    apply(1, 16'hFFF9, reqs('{5}), 0);
    apply(0, 16'hFFF8, reqs('{5}), 0);
    apply(1, 16'hFFF6, reqs('{5}), 0);
    apply(1, 16'hFFFA, reqs('{5}), 0);
    apply(1, 16'h7FF8, reqs('{5}), 0);
    apply(1, 16'hFEF8, reqs('{2}), 0);

    curReq = "R3";
    for (int i = 0; i < 11; i++) begin
      apply(1, 16'hFFF8, reqs('{i}), 0);
      apply(1, 16'hFFF9, reqs('{i}), 0);
    end
    apply(1, 16'hFFF8, reqs('{2, 7}), 0);
    apply(1, 16'hFFF9, reqs('{6, 10}), 0);
    apply(1, 16'hFFF8, reqs('{1, 5, 9}), 0);
    apply(1, 16'hFFF8, reqs('{4, 8}), 0);

    curReq = "R4";
    apply(1, 16'hFFF8, reqs('{0, 1}), 0);
    apply(1, 16'hFFF9, reqs('{0, 1, 7}), 0);
    apply(1, 16'hFFF8, reqs('{0, 1, 3, 4}), 0);

    curReq = "R5";
    apply(1, 16'hFFF8, reqs('{3, 4}), 0);
    apply(1, 16'hFFF9, reqs('{2, 3, 4}), 0);
    apply(1, 16'hFFF8, reqs('{3, 4, 8}), 0);

    curReq = "R7";
    apply(1, 16'hFFF8, reqs('{0, 2}), 1);
    @(negedge clk);
    check("R7 released", 32'(addrDrive), 32'h0);
    check("R7 irq kept", 32'(irqN), 32'h0);
    check("R7 flags kept", 32'(flags), 32'h1);
    apply(1, 16'hFFF8, reqs('{0, 2}), 0);

    curReq = "R8";
    apply(1, 16'h0100, reqs('{9, 10}), 0);
    apply(1, 16'h0100, reqs('{5}), 0);
    apply(1, 16'h0100, reqs('{0, 2, 5, 9, 10}), 0);
    apply(1, 16'h0100, reqs('{2, 9}), 0);

    curReq = "R6";
    apply(1, 16'hFFF8, '1, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule